// File: doc/BRIEF.md
# Write Status Polling Read Path

This block forms the byte returned on the read side of a parallel nonvolatile memory and decides when that byte is driven. When no programming cycle is running it passes the array's read data through unchanged. While the array is busy programming, the byte carries status instead of stored data, so a host can poll for the end of the write. Bit 7 returns the inverse of bit 7 of the byte most recently written. Bit 6 flips on every new read access. The low six bits keep showing the old contents of the addressed cell.

The control inputs are active-low strobes that have already been synchronized to the block clock. Every output is registered, so the result of the strobes and data sampled at one rising edge appears right after that edge. The enclosing design supplies the array read data for the current address, the busy flag of the programming timer, and the top bit of the last byte written.

Top module: `poll_read_path`

## Requirements
- R1: `bus_oe` is 1 after a rising edge exactly when that edge sampled `cs_n`=0, `oe_n`=0 and `we_n`=1. Any other combination gives 0, including `we_n`=0 with the other two low.
- R2: While `bus_oe` is 0, `bus_out` is 0x00.
- R3: With `busy`=0, a read returns `bus_out` equal to the `cell_data` sampled at the same edge, on all eight bits.
- R4: With `busy`=1, a read returns bit 7 as the inverse of the `wr_msb` sampled at the same edge.
- R5: With `busy`=1, a read returns bits 5:0 equal to `cell_data[5:0]` sampled at the same edge.
- R6: A new access is an edge at which `cs_n`=0 and `oe_n`=0 are sampled while the previous edge did not sample both low, with `we_n`=1. Each new access made while `busy`=1 returns bit 6 with the opposite value from the previous access.
- R7: While a read is held with no new access, bit 6 keeps its value from one cycle to the next.
- R8: When `busy` returns to 0, the next read cycle returns the true byte, with no status bits.
- R9: An edge at which `busy` is first sampled 1 clears the toggle state. The first new access at or after that edge returns bit 6 as 1. A read already held across that edge shows bit 6 as 0.
- R10: A synchronous reset (`rst_n`=0 at an edge) gives `bus_oe`=0 and `bus_out`=0x00. The busy history is also cleared, so a `busy` of 1 at the first edge after reset counts as a new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Synchronized chip select, active low |
| oe_n | input | 1 | Synchronized output enable, active low |
| we_n | input | 1 | Synchronized write strobe, active low |
| busy | input | 1 | Programming cycle in progress |
| wr_msb | input | 1 | Bit 7 of the last byte written |
| cell_data | input | 8 | Array read data for the current address |
| bus_out | output | 8 | Byte for the bus drivers |
| bus_oe | output | 1 | Tri-state enable for the bus drivers |

## Verification
The assertions assume that the strobes, `busy` and `wr_msb` are already synchronous to `clk` and settle between edges. They also assume that `busy` rises only while a write strobe is or was just present. The bench drives every input on the falling clock edge and samples the outputs on the next falling edge, one register later. It moves the busy flag only at the points where a real programming timer would: after a write strobe, and back to 0 between accesses or during a held read.

// File: rtl/poll_pkg.sv
// Package: poll_pkg
// Shared widths and bit positions of the status polling read path.
// Assumes an eight-bit bus; the status bit positions are fixed by what a
// polling host decodes, so they are constants rather than free parameters.
package poll_pkg;
    localparam int unsigned BUS_W      = 8;
    localparam int unsigned POLL_BIT   = 7;   // inverted last-write bit
    localparam int unsigned TOGGLE_BIT = 6;   // flips per access while busy

    // Synchronized active-low bus strobes
    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
    } strobe_t;
endpackage

// File: rtl/poll_access_det.sv
// Module: poll_access_det
// Decodes a read cycle from the synchronized strobes and marks the first
// cycle of each new access (select-and-output-enable newly both low).
// Assumes strobes are synchronous to clk.
module poll_access_det
    import poll_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  strobe_t strobe,
    output logic    rd_cycle,
    output logic    new_access
);
    logic sel_now;
    logic sel_prev;

    // Purpose: chip selected with output enabled, regardless of write strobe
    always_comb sel_now = !strobe.cs_n && !strobe.oe_n;

    // Purpose: a read needs the write strobe idle
    always_comb rd_cycle = sel_now && strobe.we_n;

    // Purpose: new access on the cycle the selection first appears
    always_comb new_access = rd_cycle && !sel_prev;

    // Purpose: remember last cycle's selection for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sel_prev <= 1'b0;
        else        sel_prev <= sel_now;
    end

    // R6
    new_access_is_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_access |-> (!strobe.cs_n && !strobe.oe_n && strobe.we_n));
    // R6
    no_double_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_access |=> !new_access);
endmodule

// File: rtl/poll_toggle.sv
// Module: poll_toggle
// Holds the toggle-bit state. Cleared when busy first appears, flipped
// once per new access while busy. Presents the bit value for this cycle's
// read (already reflecting a flip caused by this cycle's access).
// Assumes busy is synchronous to clk.
module poll_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic new_access,
    output logic tog_show
);
    logic busy_prev;
    logic tog_q;
    logic busy_start;
    logic tog_base;

    // Purpose: busy edge marks the start of a programming cycle
    always_comb busy_start = busy && !busy_prev;

    // Purpose: toggle value before this cycle's access, after any clear
    always_comb tog_base = busy_start ? 1'b0 : tog_q;

    // Purpose: bit shown this cycle; a new access while busy flips it
    always_comb tog_show = (new_access && busy) ? !tog_base : tog_base;

    // Purpose: track busy history for start detection
    always_ff @(posedge clk) begin
        if (!rst_n) busy_prev <= 1'b0;
        else        busy_prev <= busy;
    end

    // Purpose: store toggle state
    always_ff @(posedge clk) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_show;
    end

    // R6
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (new_access && busy && busy_prev) |=> (tog_q != $past(tog_q)));
    // R7
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!new_access && !(busy && !busy_prev)) |=> $stable(tog_q));
    // R9
    toggle_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !busy_prev && new_access) |=> tog_q);
endmodule

// File: rtl/poll_out_stage.sv
// Module: poll_out_stage
// Builds the returned byte (true data or status pattern) and registers it
// with the output enable. Output byte is forced to zero when not driven.
// Assumes all inputs are synchronous to clk.
module poll_out_stage
    import poll_pkg::*;
#(
    parameter int unsigned WIDTH = BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_cycle,
    input  logic             busy,
    input  logic             wr_msb,
    input  logic             tog_show,
    input  logic [WIDTH-1:0] cell_data,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe
);
    logic [WIDTH-1:0] status_word;
    logic [WIDTH-1:0] next_word;

    // Purpose: per-bit choice of status content during busy
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (b == POLL_BIT) begin : g_poll
            always_comb status_word[b] = !wr_msb;
        end else if (b == TOGGLE_BIT) begin : g_tog
            always_comb status_word[b] = tog_show;
        end else begin : g_pass
            always_comb status_word[b] = cell_data[b];
        end
    end

    // Purpose: select true data, status, or zero for an undriven bus
    always_comb begin
        if (!rd_cycle)  next_word = '0;
        else if (busy)  next_word = status_word;
        else            next_word = cell_data;
    end

    // Purpose: register the bus byte and its enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_out <= '0;
            bus_oe  <= 1'b0;
        end else begin
            bus_out <= next_word;
            bus_oe  <= rd_cycle;
        end
    end

    // R2
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));
    // R4
    poll_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cycle && busy) |=> (bus_out[POLL_BIT] == !$past(wr_msb)));
    // R5
    low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cycle && busy) |=> (bus_out[5:0] == $past(cell_data[5:0])));
    // R3
    true_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cycle && !busy) |=> (bus_out == $past(cell_data)));
endmodule

// File: rtl/poll_read_path.sv
// Module: poll_read_path (top)
// Read-side byte and tri-state control of a parallel nonvolatile memory,
// returning status (inverted last-write bit 7, toggling bit 6) while a
// programming cycle is busy. Assumes strobes are pre-synchronized.
module poll_read_path
    import poll_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic             busy,
    input  logic             wr_msb,
    input  logic [BUS_W-1:0] cell_data,
    output logic [BUS_W-1:0] bus_out,
    output logic             bus_oe
);
    strobe_t strobe;
    logic    rd_cycle;
    logic    new_access;
    logic    tog_show;

    // Purpose: bundle the strobes for the decoder
    always_comb strobe = '{cs_n: cs_n, oe_n: oe_n, we_n: we_n};

    poll_access_det u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .rd_cycle   (rd_cycle),
        .new_access (new_access)
    );

    poll_toggle u_tog (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .new_access (new_access),
        .tog_show   (tog_show)
    );

    poll_out_stage #(.WIDTH(BUS_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_cycle  (rd_cycle),
        .busy      (busy),
        .wr_msb    (wr_msb),
        .tog_show  (tog_show),
        .cell_data (cell_data),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe)
    );

    // R1
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bus_oe == $past(!cs_n && !oe_n && we_n)));
endmodule

// File: tb/poll_read_path_tb.sv
module poll_read_path_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic       busy = 1'b0, wr_msb = 1'b0;
    logic [7:0] cell_data = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    poll_read_path u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .busy(busy), .wr_msb(wr_msb), .cell_data(cell_data),
        .bus_out(bus_out), .bus_oe(bus_oe)
    );

    typedef struct packed {
        logic       cs_n, oe_n, we_n, busy, msb;
        logic [7:0] data;
        logic       e_oe;
        logic [7:0] e_out;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{1,1,1,0,0,8'hA5,0,8'h00,8'd2},  // R2 idle
        '{0,0,1,0,0,8'h3C,1,8'h3C,8'd3},  // R3 plain read
        '{0,0,1,0,0,8'h7E,1,8'h7E,8'd3},  // R3 data follows
        '{0,0,0,0,0,8'h11,0,8'h00,8'd1},  // R1 write strobe blocks drive
        '{0,1,0,1,1,8'h00,0,8'h00,8'd1},  // R1 busy starts, no read
        '{0,0,1,1,1,8'h2A,1,8'h6A,8'd6},  // R4 R5 R6 first poll
        '{0,0,1,1,1,8'h15,1,8'h55,8'd7},  // R7 held read
        '{0,1,1,1,1,8'h00,0,8'h00,8'd2},
        '{0,0,1,1,1,8'h3F,1,8'h3F,8'd6},  // R6 second poll flips
        '{0,1,1,1,1,8'h00,0,8'h00,8'd2},
        '{0,0,1,1,0,8'h01,1,8'hC1,8'd4},  // R4 R6 third poll
        '{1,0,1,1,0,8'h00,0,8'h00,8'd1},  // R1 deselected
        '{0,0,1,1,0,8'h00,1,8'h80,8'd6},  // R6 access by select edge
        '{0,0,1,0,0,8'hF0,1,8'hF0,8'd8},  // R8 busy ends
        '{0,0,1,0,0,8'h9B,1,8'h9B,8'd8},  // R8
        '{0,1,1,0,0,8'h00,0,8'h00,8'd2},
        '{0,0,1,1,0,8'h00,1,8'hC0,8'd9},  // R9 busy start with access
        '{0,1,1,1,0,8'h00,0,8'h00,8'd2},
        '{0,0,1,1,0,8'h00,1,8'h80,8'd6},  // R6 flips to 0
        '{0,0,1,0,0,8'h55,1,8'h55,8'd8},  // R8 held, busy ends
        '{0,0,1,1,1,8'h00,1,8'h00,8'd9},  // R9 busy start mid read shows 0
        '{0,1,1,1,1,8'h00,0,8'h00,8'd2},
        '{0,0,1,1,1,8'h00,1,8'h40,8'd9}   // R9 first poll after clear is 1
    };

    task automatic check(input logic e_oe, input logic [7:0] e_out, input int req);
        n_chk++;
        if (bus_oe !== e_oe || bus_out !== e_out) begin
            n_fail++;
            $display("FAIL R%0d: got oe=%b out=%h expected oe=%b out=%h",
                     req, bus_oe, bus_out, e_oe, e_out);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        step(); step();
        check(1'b0, 8'h00, 10);           // R10 reset state
        rst_n = 1'b1;
        step();
        for (int i = 0; i < NV; i++) begin
            cs_n = VEC[i].cs_n; oe_n = VEC[i].oe_n; we_n = VEC[i].we_n;
            busy = VEC[i].busy; wr_msb = VEC[i].msb; cell_data = VEC[i].data;
            step();
            check(VEC[i].e_oe, VEC[i].e_out, int'(VEC[i].req));
        end
        // R10 reset during a read
        cs_n = 0; oe_n = 0; we_n = 1; busy = 0; cell_data = 8'h77;
        step();
        check(1'b1, 8'h77, 3);            // R3
        rst_n = 1'b0;
        step();
        check(1'b0, 8'h00, 10);           // R10
        // R10 busy after reset counts as new write; held read is new access
        busy = 1; wr_msb = 0; cell_data = 8'h00; rst_n = 1'b1;
        step();
        check(1'b1, 8'hC0, 10);           // R10 R9
        cell_data = 8'h3F;
        step();
        check(1'b1, 8'hFF, 7);            // R7 bit 6 held, R5 low bits
        busy = 0; oe_n = 1;
        step();
        check(1'b0, 8'h00, 2);            // R2
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1: watchdog expired, got no completion expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule